// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the architectural register state of a 32-bit load/store processor core. It shows sixteen registers to the datapath at any moment. Which physical storage sits behind an index depends on the operating mode held in the current status word. Low indices always map to one common set. The fast-interrupt mode swaps in a private upper group. The other exception modes swap in private copies of only the stack pointer (index 13) and the link register (index 14). Index 15 is the program counter. It can be reached through the normal ports or through a dedicated path.

The file also holds the current status word and one saved status word for each exception mode. Taking an exception is a single request. It copies the current status into the saved slot of the target mode and switches the mode in the same edge. The instruction decoder drives the indices and enables. The exception sequencer decides when `exc_take` is raised.

Top module: `banked_regfile`

## Requirements
- R1: Two combinational read ports and one write port address indices 0..15. A write lands at the rising clock edge. A read of the register being written in the same cycle returns the old value.
- R2: Indices 0..7 map to one physical set in every mode. A value written in one mode is read back unchanged in any other mode.
- R3: In fast-interrupt mode (code 1), indices 8..14 map to a private set. That set is separate from the copies seen in all other modes.
- R4: In the interrupt (2), supervisor (3), abort (4) and undefined (5) modes, indices 13 and 14 map to a private pair per mode. Indices 8..12 are shared with user mode (code 0, user/system).
- R5: Index 15 is the program counter on both read ports, and a general write to index 15 updates it. `pc_we` writes `pc_wd` through the dedicated path. It wins over a general write to index 15 in the same cycle. `pc_q` always shows the counter.
- R6: While `rst_n` is low, the mode becomes supervisor (`cpsr_q` = 32'h3). All registers, the program counter and every saved status word are cleared.
- R7: The mode is held in `cpsr_q[2:0]`. In a non-user mode, `sr_we` loads the whole word from `sr_wd`. If `sr_wd[2:0]` is 6 or 7, the mode bits keep their old value.
- R8: In user mode, `sr_we` loads `cpsr_q[31:3]`, but the mode bits stay 0.
- R9: When `exc_take` is high with `exc_mode` in 1..5, the old `cpsr_q` goes into that mode's saved slot and the mode field becomes `exc_mode`. Higher bits of `cpsr_q` are kept. This wins over `sr_we` and `spsr_we` in the same cycle. Register writes in that cycle use the old mode. A code of 0, 6 or 7 is ignored.
- R10: `spsr_rd` shows the saved status word of the current mode, and `spsr_we` writes it. In user mode `spsr_rd` reads zero and `spsr_we` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ra_idx | input | 4 | Read port A index |
| ra_data | output | 32 | Read port A data |
| rb_idx | input | 4 | Read port B index |
| rb_data | output | 32 | Read port B data |
| wr_en | input | 1 | General write enable |
| wr_idx | input | 4 | General write index |
| wr_data | input | 32 | General write data |
| pc_we | input | 1 | Dedicated program counter write |
| pc_wd | input | 32 | Dedicated program counter data |
| pc_q | output | 32 | Program counter |
| sr_we | input | 1 | Current status write enable |
| sr_wd | input | 32 | Current status write data |
| cpsr_q | output | 32 | Current status word |
| mode_o | output | 3 | Current mode code |
| spsr_we | input | 1 | Saved status write for current mode |
| spsr_wd | input | 32 | Saved status write data |
| spsr_rd | output | 32 | Saved status of current mode |
| exc_take | input | 1 | Exception entry request |
| exc_mode | input | 3 | Target mode of the exception |

## Verification
Some rules are checked on every cycle: the user-mode lock on the mode field, the zero saved status in user mode, the status copy and mode switch on exception entry, the dedicated counter path, and read-after-write of the shared low set across any mode. The bench's scenarios are needed for the banking itself. They show that a private copy is really separate, that the interrupt-class modes share indices 8..12 with user mode, that same-cycle reads return old data, and that the saved slots are kept per mode. Each of those only shows up after a sequence of mode switches.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    ra_idx,
  output logic [DW-1:0] ra_data,
  input  logic [3:0]    rb_idx,
  output logic [DW-1:0] rb_data,
  input  logic          wr_en,
  input  logic [3:0]    wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          pc_we,
  input  logic [DW-1:0] pc_wd,
  output logic [DW-1:0] pc_q,
  input  logic          sr_we,
  input  logic [DW-1:0] sr_wd,
  output logic [DW-1:0] cpsr_q,
  output logic [2:0]    mode_o,
  input  logic          spsr_we,
  input  logic [DW-1:0] spsr_wd,
  output logic [DW-1:0] spsr_rd,
  input  logic          exc_take,
  input  logic [2:0]    exc_mode
);
  localparam logic [2:0] M_USR = 3'd0;
  localparam logic [2:0] M_FIQ = 3'd1;
  localparam logic [2:0] M_IRQ = 3'd2;
  localparam logic [2:0] M_SVC = 3'd3;
  localparam logic [2:0] M_UND = 3'd5;
  localparam int NSHR  = 8;
  localparam int NUPR  = 7;
  localparam int NPAIR = 4;
  localparam int NREG  = NSHR + 2 * NUPR + 2 * NPAIR;

  logic [DW-1:0] bank [NREG];
  logic [DW-1:0] saved [1:5];
  logic [DW-1:0] pc, cpsr;
  logic [2:0]    mode;
  logic          priv, exc_ok;

  function automatic logic [4:0] phys(input logic [3:0] i, input logic [2:0] m);
    logic [2:0] mm;
    mm = m - M_IRQ;
    if (!i[3])                              return {1'b0, i};
    else if (m == M_FIQ)                    return {1'b0, i} + 5'd7;
    else if (i >= 4'd13 && m >= M_IRQ && m <= M_UND)
                                            return 5'd22 + {2'b0, mm[1:0], ~i[0]};
    else                                    return {1'b0, i};
  endfunction

  assign mode   = cpsr[2:0];
  assign priv   = (mode != M_USR);
  assign exc_ok = exc_take && (exc_mode != M_USR) && (exc_mode <= M_UND);

  assign ra_data = (ra_idx == 4'd15) ? pc : bank[phys(ra_idx, mode)];
  assign rb_data = (rb_idx == 4'd15) ? pc : bank[phys(rb_idx, mode)];
  assign spsr_rd = priv ? saved[mode] : '0;
  assign pc_q    = pc;
  assign cpsr_q  = cpsr;
  assign mode_o  = mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) bank[k] <= '0;
      for (int k = 1; k <= 5; k++) saved[k] <= '0;
      pc   <= '0;
      cpsr <= {{(DW-3){1'b0}}, M_SVC};
    end else begin
      if (wr_en && wr_idx != 4'd15) bank[phys(wr_idx, mode)] <= wr_data;

      if (pc_we)                          pc <= pc_wd;
      else if (wr_en && wr_idx == 4'd15)  pc <= wr_data;

      if (exc_ok)
        cpsr <= {cpsr[DW-1:3], exc_mode};
      else if (sr_we)
        cpsr <= {sr_wd[DW-1:3], (priv && sr_wd[2:0] <= M_UND) ? sr_wd[2:0] : mode};

      if (exc_ok)                saved[exc_mode] <= cpsr;
      else if (spsr_we && priv)  saved[mode]     <= spsr_wd;
    end
  end
endmodule

module regfile_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    ra_idx,
  input logic [DW-1:0] ra_data,
  input logic          wr_en,
  input logic [3:0]    wr_idx,
  input logic [DW-1:0] wr_data,
  input logic          pc_we,
  input logic [DW-1:0] pc_wd,
  input logic [DW-1:0] pc_q,
  input logic          sr_we,
  input logic [DW-1:0] cpsr_q,
  input logic [2:0]    mode_o,
  input logic [DW-1:0] spsr_rd,
  input logic          exc_take,
  input logic [2:0]    exc_mode
);
  // R8
  user_mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd0 && sr_we && !exc_take) |=> (mode_o == 3'd0));

  // R10
  user_spsr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd0) |-> (spsr_rd == '0));

  // R9
  exc_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && exc_mode != 3'd0 && exc_mode <= 3'd5)
      |=> (mode_o == $past(exc_mode) && spsr_rd == $past(cpsr_q)));

  // R5
  pc_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |=> (pc_q == $past(pc_wd)));

  // R2
  shared_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx < 4'd8)
      |=> (ra_idx != $past(wr_idx) || ra_data == $past(wr_data)));
endmodule

bind banked_regfile regfile_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_banked_regfile.sv
module sim_banked_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ra_idx = '0, rb_idx = '0, wr_idx = '0;
  logic [31:0] ra_data, rb_data, pc_q, cpsr_q, spsr_rd;
  logic        wr_en = 1'b0, pc_we = 1'b0, sr_we = 1'b0, spsr_we = 1'b0, exc_take = 1'b0;
  logic [31:0] wr_data = '0, pc_wd = '0, sr_wd = '0, spsr_wd = '0;
  logic [2:0]  mode_o, exc_mode = '0;
  int n_chk = 0, n_bad = 0;

  always #2ns clk = ~clk;

  banked_regfile u0 (.*);

  // {wmode, widx, wdata, rmode, ridx, expected}
  localparam logic [77:0] VEC [10] = '{
    {3'd3, 4'd5,  32'h11, 3'd1, 4'd5,  32'h11},
    {3'd1, 4'd9,  32'h22, 3'd0, 4'd9,  32'h0},
    {3'd0, 4'd9,  32'h33, 3'd1, 4'd9,  32'h22},
    {3'd2, 4'd10, 32'h44, 3'd0, 4'd10, 32'h44},
    {3'd2, 4'd13, 32'h55, 3'd3, 4'd13, 32'h0},
    {3'd4, 4'd14, 32'h66, 3'd4, 4'd14, 32'h66},
    {3'd5, 4'd13, 32'h77, 3'd0, 4'd13, 32'h0},
    {3'd0, 4'd13, 32'h88, 3'd5, 4'd13, 32'h77},
    {3'd1, 4'd14, 32'h99, 3'd2, 4'd14, 32'h0},
    {3'd3, 4'd7,  32'hAA, 3'd5, 4'd7,  32'hAA}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sr_write(input logic [31:0] d);
    @(negedge clk); sr_we = 1'b1; sr_wd = d;
    @(negedge clk); sr_we = 1'b0;
  endtask

  task automatic exc(input logic [2:0] m);
    @(negedge clk); exc_take = 1'b1; exc_mode = m;
    @(negedge clk); exc_take = 1'b0;
  endtask

  task automatic wreg(input logic [3:0] i, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_idx = i; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic set_mode(input logic [2:0] m);
    if (mode_o == m) return;
    if (mode_o == 3'd0) exc(m);
    else sr_write({29'b0, m});
  endtask

  task automatic rd(input logic [3:0] i, output logic [31:0] v);
    ra_idx = i; #1; v = ra_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 mode after reset", {29'b0, mode_o}, 32'h3);
    chk("R6 status after reset", cpsr_q, 32'h3);
    chk("R6 pc after reset", pc_q, 32'h0);
    chk("R6 saved status after reset", spsr_rd, 32'h0);
    rd(4'd0, v); chk("R6 r0 after reset", v, 32'h0);

    for (int n = 0; n < 10; n++) begin
      set_mode(VEC[n][77:75]);
      wreg(VEC[n][74:71], VEC[n][70:39]);
      set_mode(VEC[n][38:36]);
      rd(VEC[n][35:32], v);
      chk($sformatf("R2/R3/R4 banking vector %0d", n), v, VEC[n][31:0]);
    end

    set_mode(3'd3);
    wreg(4'd4, 32'h100);
    @(negedge clk); wr_en = 1'b1; wr_idx = 4'd4; wr_data = 32'h200; ra_idx = 4'd4; #1;
    chk("R1 same-cycle read returns old", ra_data, 32'h100);
    @(negedge clk); wr_en = 1'b0; #1;
    chk("R1 write visible after edge", ra_data, 32'h200);
    rb_idx = 4'd4; #1;
    chk("R1 second read port", rb_data, 32'h200);

    @(negedge clk); pc_we = 1'b1; pc_wd = 32'h400;
    @(negedge clk); pc_we = 1'b0; #1;
    chk("R5 dedicated pc write", pc_q, 32'h400);
    wreg(4'd15, 32'h500);
    rd(4'd15, v); chk("R5 index 15 reads pc", v, 32'h500);
    @(negedge clk); pc_we = 1'b1; pc_wd = 32'h600; wr_en = 1'b1; wr_idx = 4'd15; wr_data = 32'h700;
    @(negedge clk); pc_we = 1'b0; wr_en = 1'b0; #1;
    chk("R5 dedicated path wins", pc_q, 32'h600);

    sr_write(32'hA000_0007);
    chk("R7 invalid mode code keeps mode", cpsr_q, 32'hA000_0003);
    exc(3'd7);
    chk("R9 invalid exception code ignored", cpsr_q, 32'hA000_0003);

    @(negedge clk); spsr_we = 1'b1; spsr_wd = 32'h1234;
    @(negedge clk); spsr_we = 1'b0; #1;
    chk("R10 saved status write in supervisor", spsr_rd, 32'h1234);

    sr_write(32'h0);
    chk("R7 privileged write to user", {29'b0, mode_o}, 32'h0);
    chk("R10 user saved status reads zero", spsr_rd, 32'h0);
    @(negedge clk); spsr_we = 1'b1; spsr_wd = 32'hDEAD;
    @(negedge clk); spsr_we = 1'b0; #1;
    chk("R10 user saved status write dropped", spsr_rd, 32'h0);

    sr_write(32'hF000_0005);
    chk("R8 user cannot change mode", cpsr_q, 32'hF000_0000);

    @(negedge clk); exc_take = 1'b1; exc_mode = 3'd2; wr_en = 1'b1; wr_idx = 4'd13; wr_data = 32'h5A;
    @(negedge clk); exc_take = 1'b0; wr_en = 1'b0; #1;
    chk("R9 exception mode", cpsr_q, 32'hF000_0002);
    chk("R9 status copied to saved slot", spsr_rd, 32'hF000_0000);
    rd(4'd13, v); chk("R9 irq r13 untouched by entry-cycle write", v, 32'h55);
    sr_write(32'h3);
    chk("R10 supervisor saved slot kept", spsr_rd, 32'h1234);
    sr_write(32'h0);
    rd(4'd13, v); chk("R9 entry-cycle write used old mode", v, 32'h5A);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule